// File: doc/BRIEF.md
# Load-Adaptive Hopping PWM Period Generator

This block sets the switching rhythm of a flyback PWM controller. It reads an unsigned load code from a digitised error amplifier. From that code it works out how long each switching cycle lasts, in clock ticks. It gives out a one-clock pulse at the start of every cycle, the length of the cycle that pulse opens, and a flag that marks the deep light-load state.

The block has three load regions:

- **Heavy load:** the base frequency is a fixed nominal value of 42 kHz.
- **Middle band:** the base frequency falls in a straight line between two load thresholds, from the nominal value down to a minimum of 550 Hz.
- **Deep-green:** below the lower threshold the frequency stays at the minimum and the flag is raised.

Outside deep-green, a slow triangular frequency hop is added on top of the base frequency to spread the switching energy for EMI. The hop spans plus or minus 2.6 kHz around the base, and a full sweep takes about 3 ms at the defaults.

The load code, the hop position and the deep-green state are all taken only when a cycle starts. A cycle that is already running is never shortened or stretched by a change of load. Holding the enable low freezes the block.

Top module: `hop_pwm_period`

## Requirements
- R1: After reset, `cyc_start_o` is 0, `period_o` equals floor(CLK_HZ / F_NOM_HZ) and `deep_green_o` is 0.
- R2: `cyc_start_o` is high for exactly one clock. Two consecutive pulses are separated by exactly the value `period_o` showed after the first of them, counted in clocks with `en_i` high.
- R3: When the load code is at least NOM_CODE, the base frequency is F_NOM_HZ.
- R4: Outside deep-green, a hop offset is added to the base frequency. The offset is h × HOP_SPAN_HZ / HOP_STEPS, rounded toward zero. The index h starts at 0 after reset, moving upward. At every cycle start that is not deep-green, h moves by one step. It reverses direction when it reaches +HOP_STEPS or −HOP_STEPS, so a full sweep takes 4 × HOP_STEPS cycles.
- R5: For DEEP_CODE ≤ code < NOM_CODE, the base frequency is F_MIN_HZ + (code − DEEP_CODE) × (F_NOM_HZ − F_MIN_HZ) / (NOM_CODE − DEEP_CODE), using integer division.
- R6: When the code is below DEEP_CODE, the frequency is exactly F_MIN_HZ with no hop. The hop index h is held unchanged, and `deep_green_o` is 1 for that cycle.
- R7: The frequency in use never goes below F_MIN_HZ; a hop that would push it lower is clamped to F_MIN_HZ. The period is floor(CLK_HZ / frequency).
- R8: The load code is sampled only at a cycle start. A change in the middle of a cycle leaves that cycle's length, `period_o` and `deep_green_o` unchanged.
- R9: While `en_i` is low, there are no pulses, the cycle counter holds its value, and `period_o` and `deep_green_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Run enable; low freezes the block |
| load_code_i | input | CODE_W | Digitised load code (0 V to 5 V full scale) |
| cyc_start_o | output | 1 | One-clock pulse at each switching-cycle start |
| period_o | output | PER_W | Length in clocks of the cycle just started (15 bits at the defaults) |
| deep_green_o | output | 1 | High while the current cycle runs at the deep-green minimum |

## Verification
A wrong period computation or a wrong region decode shows up at the next cycle start, in two ways:

- `period_o` no longer matches the value computed from the requirement formulas.
- The count of enabled clocks to the following pulse no longer matches.

A hop index that moves when it should not, or moves the wrong way, offsets every later period from the expected triangle. This error therefore persists and is reported on every following pulse. A counter that reloads early, or keeps running while disabled, is caught at the next pulse by the interval check.

// File: rtl/hop_pwm_period.sv
module hop_pwm_period #(
  parameter int CLK_HZ      = 10_000_000,
  parameter int F_NOM_HZ    = 42_000,
  parameter int F_MIN_HZ    = 550,
  parameter int HOP_SPAN_HZ = 2_600,
  parameter int HOP_STEPS   = 32,
  parameter int CODE_W      = 8,
  parameter int NOM_CODE    = 143,
  parameter int DEEP_CODE   = 41,
  localparam int MAX_PER    = CLK_HZ / F_MIN_HZ,
  localparam int PER_W      = $clog2(MAX_PER + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [CODE_W-1:0] load_code_i,
  output logic              cyc_start_o,
  output logic [PER_W-1:0]  period_o,
  output logic              deep_green_o
);

  localparam int NOM_PER = CLK_HZ / F_NOM_HZ;
  localparam int HW      = $clog2(HOP_STEPS + 1) + 1;

  logic [PER_W-1:0]     cnt_q;
  logic [PER_W-1:0]     period_q;
  logic [PER_W-1:0]     per_next;
  logic                 start_q;
  logic                 deep_q;
  logic                 up_q;
  logic signed [HW-1:0] hop_q;
  logic                 deep_now;
  logic                 boundary;

  assign deep_now = int'(load_code_i) < DEEP_CODE;
  assign boundary = en_i && (cnt_q == '0);

  always_comb begin
    int code;
    int f_base;
    int hop_df;
    int f_use;
    code   = int'(load_code_i);
    hop_df = int'(hop_q) * HOP_SPAN_HZ / HOP_STEPS;
    if (code >= NOM_CODE)
      f_base = F_NOM_HZ;
    else if (deep_now)
      f_base = F_MIN_HZ;
    else
      f_base = F_MIN_HZ + (code - DEEP_CODE) * (F_NOM_HZ - F_MIN_HZ) / (NOM_CODE - DEEP_CODE);
    f_use = deep_now ? f_base : f_base + hop_df;
    if (f_use < F_MIN_HZ)
      f_use = F_MIN_HZ;
    per_next = PER_W'(CLK_HZ / f_use);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      period_q <= PER_W'(NOM_PER);
      start_q  <= 1'b0;
      deep_q   <= 1'b0;
      up_q     <= 1'b1;
      hop_q    <= '0;
    end else begin
      start_q <= 1'b0;
      if (boundary) begin
        start_q  <= 1'b1;
        cnt_q    <= per_next - PER_W'(1);
        period_q <= per_next;
        deep_q   <= deep_now;
        if (!deep_now) begin
          if (up_q) begin
            hop_q <= hop_q + HW'(1);
            if (int'(hop_q) == HOP_STEPS - 1) up_q <= 1'b0;
          end else begin
            hop_q <= hop_q - HW'(1);
            if (int'(hop_q) == 1 - HOP_STEPS) up_q <= 1'b1;
          end
        end
      end else if (en_i) begin
        cnt_q <= cnt_q - PER_W'(1);
      end
    end
  end

  assign cyc_start_o  = start_q;
  assign period_o     = period_q;
  assign deep_green_o = deep_q;

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> !start_q); // R2

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> (cnt_q == period_q - PER_W'(1))); // R2

  AST_NO_PULSE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !start_q); // R9

  AST_FROZEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> ($stable(cnt_q) && $stable(period_q))); // R9

  AST_PERIOD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !start_q |-> ($stable(period_q) && $stable(deep_q))); // R8

  AST_DEEP_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (start_q && deep_q) |-> (period_q == PER_W'(MAX_PER))); // R6

  AST_HOP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(hop_q) <= HOP_STEPS) && (int'(hop_q) >= -HOP_STEPS)); // R4

  AST_PERIOD_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    int'(period_q) <= MAX_PER); // R7

endmodule

// File: tb/test_hop_pwm_period.sv
`timescale 1ns/1ps
module test_hop_pwm_period;
  localparam int CLK_HZ = 2_000_000;
  localparam int FNOM   = 42_000;
  localparam int FMIN   = 550;
  localparam int SPAN   = 2_600;
  localparam int STEPS  = 4;
  localparam int NOMC   = 143;
  localparam int DEEPC  = 41;
  localparam int PER_W  = $clog2(CLK_HZ / FMIN + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_i = 1'b0;
  logic [7:0] code_i = 8'd0;
  logic cyc_start_o;
  logic [PER_W-1:0] period_o;
  logic deep_green_o;

  always #2.5 clk = ~clk;

  hop_pwm_period #(.CLK_HZ(CLK_HZ), .F_NOM_HZ(FNOM), .F_MIN_HZ(FMIN),
    .HOP_SPAN_HZ(SPAN), .HOP_STEPS(STEPS), .CODE_W(8),
    .NOM_CODE(NOMC), .DEEP_CODE(DEEPC)) i_hop_pwm_period (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .load_code_i(code_i),
    .cyc_start_o(cyc_start_o), .period_o(period_o), .deep_green_o(deep_green_o));

  int tests = 0;
  int fails = 0;
  int q_per[$];
  int q_deep[$];
  string q_tag[$];
  int m_h = 0;
  bit m_up = 1'b1;
  int seen = 0;
  longint ecount = 0;
  longint last_e = 0;
  int prev_per = 0;
  bit first = 1'b1;
  bit prev_start = 1'b0;
  int cyc = 0;

  task automatic check(bit ok, string tag, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push_cycles(int code, int n, int dly, string tag);
    repeat (dly) @(negedge clk);
    code_i = code[7:0];
    for (int i = 0; i < n; i++) begin
      bit deep;
      int fb;
      int f;
      deep = code < DEEPC;
      if (code >= NOMC) fb = FNOM;
      else if (deep) fb = FMIN;
      else fb = FMIN + (code - DEEPC) * (FNOM - FMIN) / (NOMC - DEEPC);
      f = deep ? fb : fb + m_h * SPAN / STEPS;
      if (f < FMIN) f = FMIN;
      q_per.push_back(CLK_HZ / f);
      q_deep.push_back(int'(deep));
      q_tag.push_back(tag);
      if (!deep) begin
        if (m_up) begin
          m_h++;
          if (m_h == STEPS) m_up = 1'b0;
        end else begin
          m_h--;
          if (m_h == -STEPS) m_up = 1'b1;
        end
      end
    end
  endtask

  task automatic wait_pulses(int n);
    int target;
    target = seen + n;
    while (seen < target) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (rst_n && en_i) ecount++;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_start && cyc_start_o)
        check(1'b0, "R2 pulse width", 1, 0);
      if (cyc_start_o) begin
        if (q_per.size() == 0) begin
          check(1'b0, "R2 unexpected pulse", 1, 0);
        end else begin
          int ep;
          int ed;
          string tg;
          ep = q_per.pop_front();
          ed = q_deep.pop_front();
          tg = q_tag.pop_front();
          check(int'(period_o) == ep, {tg, " period"}, int'(period_o), ep);
          check(int'(deep_green_o) == ed, {tg, " R6 deep flag"}, int'(deep_green_o), ed);
          if (!first)
            check(int'(ecount - last_e) == prev_per, "R2 interval",
                  int'(ecount - last_e), prev_per);
        end
        first = 1'b0;
        last_e = ecount;
        prev_per = int'(period_o);
        seen++;
      end
      prev_start = cyc_start_o;
    end
  end

  always @(posedge clk) begin
    if (cyc > 190_000) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190_000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check(cyc_start_o == 1'b0, "R1 start", int'(cyc_start_o), 0);
    check(int'(period_o) == CLK_HZ / FNOM, "R1 period", int'(period_o), CLK_HZ / FNOM);
    check(deep_green_o == 1'b0, "R1 deep", int'(deep_green_o), 0);
    rst_n = 1'b1;
    code_i = 8'd200;
    repeat (50) @(negedge clk);
    check(cyc_start_o == 1'b0 && seen == 0, "R9 idle while disabled", seen, 0);
    check(int'(period_o) == CLK_HZ / FNOM, "R9 period held", int'(period_o), CLK_HZ / FNOM);

    push_cycles(200, 20, 0, "R3 R4 heavy hop");
    en_i = 1'b1;
    wait_pulses(20);
    push_cycles(NOMC, 4, 0, "R3 threshold");
    wait_pulses(4);
    push_cycles(92, 6, 0, "R5 linear");
    wait_pulses(6);
    push_cycles(DEEPC, 8, 0, "R7 clamp");
    wait_pulses(8);
    push_cycles(10, 3, 0, "R6 deep");
    wait_pulses(3);
    push_cycles(0, 1, 0, "R6 deep zero");
    wait_pulses(1);

    push_cycles(200, 3, 1000, "R8 midcycle");
    check(int'(period_o) == CLK_HZ / FMIN, "R8 period held", int'(period_o), CLK_HZ / FMIN);
    check(deep_green_o == 1'b1, "R8 deep held", int'(deep_green_o), 1);
    wait_pulses(3);

    push_cycles(200, 3, 0, "R4 resume");
    repeat (5) @(negedge clk);
    en_i = 1'b0;
    begin
      int p0;
      bit quiet;
      p0 = int'(period_o);
      quiet = 1'b1;
      repeat (40) begin
        @(negedge clk);
        if (cyc_start_o || int'(period_o) != p0) quiet = 1'b0;
      end
      check(quiet, "R9 frozen", int'(period_o), p0);
    end
    en_i = 1'b1;
    wait_pulses(3);

    push_cycles(60, 5, 0, "R5 linear low");
    wait_pulses(5);
    check(q_per.size() == 0, "R2 queue drained", q_per.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule